// File: doc/BRIEF.md
# Integer Shift and Rotate Unit

A purely combinational shifter for the execute stage of a 32-register RISC integer pipeline. From the decoded instruction it takes the 6-bit function code, the 5-bit shift-amount field and the three 5-bit register-number fields, together with the two source operand values. It returns the shifted or rotated value of the second operand and a write-enable for that result. The unit covers four kinds of move: left logical, right logical, right arithmetic and right rotate. Each kind can use either the immediate shift-amount field or the low five bits of the first operand as its count.

Rotation has no function code of its own. It reuses the two right-logical codes and is selected by a spare instruction bit: the low bit of the rs field for the fixed-count form, and the low bit of the shift-amount field for the register-count form. When the left-shift code has all three register fields at zero, the instruction is one of the no-operation encodings. The unit then raises a flag that names which one it is and writes nothing.

Top module: `shift_rotate_unit`

## Requirements
- R1: Function code 0x00, when any of the rs, rt or rd fields is non-zero, asserts writeEn and gives rtVal shifted left by shamt, with zeros filling in from the right.
- R2: Function code 0x02 with rsField[0]=0 gives rtVal shifted right logically by shamt. Function code 0x03 gives rtVal shifted right arithmetically by shamt. Both assert writeEn.
- R3: Function codes 0x04 (left logical), 0x06 with shamt[0]=0 (right logical) and 0x07 (right arithmetic) shift rtVal by rsVal[4:0]. Bits 31..5 of rsVal have no effect on the result.
- R4: An arithmetic right shift fills every vacated upper position with a copy of rtVal[31].
- R5: Function code 0x02 with rsField[0]=1 gives rtVal rotated right by shamt: bits shifted out at the bottom re-enter at the top.
- R6: Function code 0x06 with shamt[0]=1 gives rtVal rotated right by rsVal[4:0].
- R7: A rotate with a count of zero returns rtVal unchanged.
- R8: Under function code 0x00 with rsField, rtField and rdField all zero, writeEn is 0 and result is 0. shamt 1 raises isSsnop, shamt 3 raises isEhb, and every other shamt value (including 0) raises isNop.
- R9: Every function code other than 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07 gives writeEn=0, result=0 and all three flags low.
- R10: At most one of isNop, isSsnop and isEhb is high at any time, and writeEn is 0 whenever any of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| funct | input | 6 | Function code of the instruction |
| shamt | input | 5 | Immediate shift-amount field |
| rsField | input | 5 | rs register-number field |
| rtField | input | 5 | rt register-number field |
| rdField | input | 5 | rd register-number field |
| rsVal | input | 32 | First operand value (supplies the variable count) |
| rtVal | input | 32 | Second operand value (the value that is shifted) |
| result | output | 32 | Shifted or rotated value, 0 when writeEn is low |
| writeEn | output | 1 | Result is to be written back |
| isNop | output | 1 | Plain no-operation encoding seen |
| isSsnop | output | 1 | Superscalar no-operation encoding seen |
| isEhb | output | 1 | Hazard-barrier encoding seen |

## Verification
The unit holds no state, so any fault in decode or in the shift network shows up on result or on the flags in the same cycle that the inputs are applied. A wrong decode strobe appears as a wrong fill pattern: zeros where sign copies belong, lost bits where a rotate should wrap them round, or a result written for a no-operation encoding. A wrong stage in the logarithmic network corrupts only those counts whose binary form includes that stage. For that reason every count from 0 to 31 is driven, and random operands are mixed in with directed edge values.

// File: rtl/shift_pkg.sv
package shift_pkg;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;

  localparam logic [4:0] SA_SSNOP = 5'd1;
  localparam logic [4:0] SA_EHB   = 5'd3;

  typedef struct packed {
    logic useReg;
    logic goLeft;
    logic arith;
    logic rotate;
    logic write;
  } shiftStrobes_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
#(
  parameter int FUNCT_W = 6,
  parameter int REG_W   = 5
) (
  input  logic [FUNCT_W-1:0] funct,
  input  logic [REG_W-1:0]   shamt,
  input  logic [REG_W-1:0]   rsField,
  input  logic [REG_W-1:0]   rtField,
  input  logic [REG_W-1:0]   rdField,
  output shiftStrobes_t      strobes,
  output logic               isNop,
  output logic               isSsnop,
  output logic               isEhb
);

  logic fieldsZero;
  assign fieldsZero = (rsField == '0) && (rtField == '0) && (rdField == '0);

  always_comb begin
    strobes = '0;
    isNop   = 1'b0;
    isSsnop = 1'b0;
    isEhb   = 1'b0;
    case (funct)
      FN_SLL: begin
        if (fieldsZero) begin
          isSsnop = (shamt == SA_SSNOP);
          isEhb   = (shamt == SA_EHB);
          isNop   = !(shamt == SA_SSNOP) && !(shamt == SA_EHB);
        end else begin
          strobes.goLeft = 1'b1;
          strobes.write  = 1'b1;
        end
      end
      FN_SRL: begin
        strobes.rotate = rsField[0];
        strobes.write  = 1'b1;
      end
      FN_SRA: begin
        strobes.arith = 1'b1;
        strobes.write = 1'b1;
      end
      FN_SLLV: begin
        strobes.useReg = 1'b1;
        strobes.goLeft = 1'b1;
        strobes.write  = 1'b1;
      end
      FN_SRLV: begin
        strobes.useReg = 1'b1;
        strobes.rotate = shamt[0];
        strobes.write  = 1'b1;
      end
      FN_SRAV: begin
        strobes.useReg = 1'b1;
        strobes.arith  = 1'b1;
        strobes.write  = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  shiftStrobes_t     strobes,
  input  logic [AMT_W-1:0]  shamt,
  input  logic [AMT_W-1:0]  regAmt,
  input  logic [DATA_W-1:0] rtVal,
  output logic [DATA_W-1:0] result
);

  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] srcOrdered;
  logic [DATA_W-1:0] outOrdered;
  logic              fillBit;
  logic [DATA_W-1:0] stage [0:AMT_W];

  assign amt     = strobes.useReg ? regAmt : shamt;
  assign fillBit = strobes.arith & rtVal[DATA_W-1];

  // left shifts reuse the right-shift network on a bit-reversed operand
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign srcOrdered[b] = strobes.goLeft ? rtVal[DATA_W-1-b] : rtVal[b];
    assign result[b]     = strobes.write ?
                           (strobes.goLeft ? outOrdered[DATA_W-1-b] : outOrdered[b]) : 1'b0;
  end

  assign stage[0] = srcOrdered;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [STEP-1:0] fill;
    assign fill = strobes.rotate ? stage[k][STEP-1:0] : {STEP{fillBit}};
    assign stage[k+1] = amt[k] ? {fill, stage[k][DATA_W-1:STEP]} : stage[k];
  end

  assign outOrdered = stage[AMT_W];

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FUNCT_W = 6,
  parameter int REG_W   = 5,
  localparam int AMT_W  = $clog2(DATA_W)
) (
  input  logic [FUNCT_W-1:0] funct,
  input  logic [REG_W-1:0]   shamt,
  input  logic [REG_W-1:0]   rsField,
  input  logic [REG_W-1:0]   rtField,
  input  logic [REG_W-1:0]   rdField,
  input  logic [DATA_W-1:0]  rsVal,
  input  logic [DATA_W-1:0]  rtVal,
  output logic [DATA_W-1:0]  result,
  output logic               writeEn,
  output logic               isNop,
  output logic               isSsnop,
  output logic               isEhb
);

  shiftStrobes_t strobes;
  logic          unusedRsHi;

  // only the low count bits of the register operand matter
  assign unusedRsHi = ^rsVal[DATA_W-1:AMT_W];

  shift_ctrl #(.FUNCT_W(FUNCT_W), .REG_W(REG_W)) i_ctrl (
    .funct   (funct),
    .shamt   (shamt),
    .rsField (rsField),
    .rtField (rtField),
    .rdField (rdField),
    .strobes (strobes),
    .isNop   (isNop),
    .isSsnop (isSsnop),
    .isEhb   (isEhb)
  );

  shift_datapath #(.DATA_W(DATA_W)) i_dp (
    .strobes (strobes),
    .shamt   (shamt[AMT_W-1:0]),
    .regAmt  (rsVal[AMT_W-1:0]),
    .rtVal   (rtVal),
    .result  (result)
  );

  assign writeEn = strobes.write;

endmodule

// File: rtl/shift_rotate_chk.sv
module shift_rotate_chk #(
  parameter int DATA_W = 32
) (
  input logic [5:0]        funct,
  input logic [4:0]        shamt,
  input logic [4:0]        rsField,
  input logic [DATA_W-1:0] rtVal,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic              isNop,
  input logic              isSsnop,
  input logic              isEhb
);

  logic known;
  assign known = !$isunknown({funct, shamt, rsField, rtVal, result, writeEn, isNop, isSsnop, isEhb});

  always_comb begin
    if (known) begin
      // R10
      flags_onehot_chk: assert ($onehot0({isNop, isSsnop, isEhb}));
      // R10
      flag_blocks_write_chk: assert (!(isNop || isSsnop || isEhb) || !writeEn);
      // R9
      idle_result_zero_chk: assert (writeEn || result == '0);
      // R7
      rotate_zero_chk: assert (!(funct == 6'h02 && rsField[0] && shamt == 5'd0) || result == rtVal);
      // R4
      sign_fill_chk: assert (!(funct == 6'h03 && rtVal[DATA_W-1]) || result[DATA_W-1]);
      // R1
      sll_low_zero_chk: assert (!(funct == 6'h00 && writeEn && shamt != 5'd0) || !result[0]);
    end
  end

endmodule

bind shift_rotate_unit shift_rotate_chk #(.DATA_W(DATA_W)) i_chk (
  .funct   (funct),
  .shamt   (shamt),
  .rsField (rsField),
  .rtVal   (rtVal),
  .result  (result),
  .writeEn (writeEn),
  .isNop   (isNop),
  .isSsnop (isSsnop),
  .isEhb   (isEhb)
);

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [5:0]  funct;
  logic [4:0]  shamt, rsField, rtField, rdField;
  logic [31:0] rsVal, rtVal, result;
  logic        writeEn, isNop, isSsnop, isEhb;

  int vecs = 0;
  int fails = 0;

  shift_rotate_unit i_shift_rotate_unit (
    .funct(funct), .shamt(shamt), .rsField(rsField), .rtField(rtField),
    .rdField(rdField), .rsVal(rsVal), .rtVal(rtVal), .result(result),
    .writeEn(writeEn), .isNop(isNop), .isSsnop(isSsnop), .isEhb(isEhb)
  );

  function automatic logic [35:0] model(input logic [5:0] f, input logic [4:0] sa,
      input logic [4:0] rsf, input logic [4:0] rtf, input logic [4:0] rdf,
      input logic [31:0] rsv, input logic [31:0] rtv);
    logic [31:0] r = 32'h0;
    logic we = 0, n = 0, s = 0, e = 0;
    int cnt;
    cnt = (f == 6'h04 || f == 6'h06 || f == 6'h07) ? int'(rsv % 32) : int'(sa);
    if (f == 6'h00) begin
      if (rsf == 0 && rtf == 0 && rdf == 0) begin
        if (sa == 1) s = 1; else if (sa == 3) e = 1; else n = 1;
      end else begin
        we = 1; r = rtv;
        for (int i = 0; i < cnt; i++) r = r * 2;
      end
    end else if (f == 6'h04) begin
      we = 1; r = rtv;
      for (int i = 0; i < cnt; i++) r = r * 2;
    end else if ((f == 6'h02 && rsf[0]) || (f == 6'h06 && sa[0])) begin
      we = 1; r = rtv;
      for (int i = 0; i < cnt; i++) r = {r[0], r[31:1]};
    end else if (f == 6'h02 || f == 6'h06) begin
      we = 1; r = rtv;
      for (int i = 0; i < cnt; i++) r = r / 2;
    end else if (f == 6'h03 || f == 6'h07) begin
      we = 1; r = rtv;
      for (int i = 0; i < cnt; i++) r = {r[31], r[31:1]};
    end
    return {r, we, n, s, e};
  endfunction

  function automatic string tagOf(input logic [5:0] f, input logic [4:0] sa,
      input logic [4:0] rsf, input logic [4:0] rtf, input logic [4:0] rdf);
    case (f)
      6'h00: return (rsf == 0 && rtf == 0 && rdf == 0) ? "R8" : "R1";
      6'h02: return rsf[0] ? (sa == 0 ? "R7" : "R5") : "R2";
      6'h03: return "R4";
      6'h04: return "R3";
      6'h06: return sa[0] ? "R6" : "R3";
      6'h07: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [5:0] f, input logic [4:0] sa, input logic [4:0] rsf,
      input logic [4:0] rtf, input logic [4:0] rdf, input logic [31:0] rsv,
      input logic [31:0] rtv, input string tag);
    logic [35:0] exp;
    logic [35:0] got;
    @(posedge clk);
    #2;
    funct = f; shamt = sa; rsField = rsf; rtField = rtf; rdField = rdf;
    rsVal = rsv; rtVal = rtv;
    @(negedge clk);
    exp = model(f, sa, rsf, rtf, rdf, rsv, rtv);
    got = {result, writeEn, isNop, isSsnop, isEhb};
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s funct=%h sa=%0d rs=%0d: actual res=%h we/n/s/e=%b expected res=%h we/n/s/e=%b",
               tag, f, sa, rsf, got[35:4], got[3:0], exp[35:4], exp[3:0]);
    end
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog R9: actual=hung expected=done");
    finishRun();
  end

  initial begin
    funct = 0; shamt = 0; rsField = 0; rtField = 0; rdField = 0; rsVal = 0; rtVal = 0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R8 state out of reset: all-zero instruction is a plain nop
    apply(6'h00, 0, 0, 0, 0, 0, 0, "R8");
    apply(6'h00, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'h1234_5678, "R8");
    apply(6'h00, 3, 0, 0, 0, 0, 32'hDEAD_BEEF, "R8");
    apply(6'h00, 2, 0, 0, 0, 0, 32'hDEAD_BEEF, "R8");
    apply(6'h00, 4, 0, 0, 1, 0, 32'h8000_0001, "R1");
    apply(6'h00, 31, 0, 2, 3, 0, 32'h0000_0003, "R1");
    apply(6'h02, 0, 0, 1, 1, 0, 32'hF000_000F, "R2");
    apply(6'h02, 31, 2, 1, 1, 0, 32'h8000_0000, "R2");
    apply(6'h03, 8, 0, 1, 1, 0, 32'h8123_4567, "R4");
    apply(6'h03, 31, 0, 1, 1, 0, 32'h7FFF_FFFF, "R4");
    apply(6'h04, 0, 5, 1, 1, 32'hFFFF_FFE4, 32'h0000_0001, "R3");
    apply(6'h06, 2, 5, 1, 1, 32'h1234_5610, 32'hFFFF_0000, "R3");
    apply(6'h07, 0, 5, 1, 1, 32'h0000_003F, 32'h8000_0000, "R4");
    apply(6'h02, 4, 1, 1, 1, 0, 32'h1234_5678, "R5");
    apply(6'h02, 0, 1, 1, 1, 0, 32'hCAFE_F00D, "R7");
    apply(6'h06, 1, 5, 1, 1, 32'h0000_0008, 32'h0000_00FF, "R6");
    apply(6'h06, 1, 5, 1, 1, 32'hFFFF_FFE0, 32'hA5A5_0F0F, "R7");
    apply(6'h01, 4, 3, 1, 1, 1, 32'hFFFF_FFFF, "R9");
    apply(6'h05, 4, 3, 1, 1, 1, 32'hFFFF_FFFF, "R9");
    apply(6'h3F, 4, 3, 1, 1, 1, 32'hFFFF_FFFF, "R9");
    // every count for every shifting kind
    for (int c = 0; c < 32; c++) begin
      apply(6'h00, 5'(c), 1, 1, 1, 0, 32'h9ABC_DEF1, "R1");
      apply(6'h02, 5'(c), 0, 1, 1, 0, 32'h9ABC_DEF1, "R2");
      apply(6'h02, 5'(c), 1, 1, 1, 0, 32'h9ABC_DEF1, "R5");
      apply(6'h03, 5'(c), 0, 1, 1, 0, 32'h9ABC_DEF1, "R4");
      apply(6'h06, 5'd1, 1, 1, 1, 32'(c), 32'h9ABC_DEF1, "R6");
      apply(6'h07, 5'd0, 1, 1, 1, 32'(c) | 32'hABC0_0000, 32'h9ABC_DEF1, "R3");
    end
    for (int i = 0; i < 3000; i++) begin
      logic [5:0]  f;
      logic [4:0]  sa, rsf, rtf, rdf;
      f = (i % 4 == 0) ? 6'($urandom) : 6'($urandom_range(0, 7));
      sa = 5'($urandom); rsf = 5'($urandom); rtf = 5'($urandom); rdf = 5'($urandom);
      if (i % 16 == 0) begin rsf = 0; rtf = 0; rdf = 0; sa = 5'($urandom_range(0, 4)); end
      apply(f, sa, rsf, rtf, rdf, $urandom, $urandom, tagOf(f, sa, rsf, rtf, rdf));
    end
    finishRun();
  end

endmodule